// File: doc/BRIEF.md
# Time-of-year calendar counter

This block keeps wall-clock time for a chip: seconds, minutes, hours, day of month and month in one packed 32-bit word, plus a full 32-bit year in a register of its own. A programmable prescaler turns a 32.768 kHz tick enable (`slow_tick`, one system-clock cycle wide per slow period) into one advance per second. The divide ratio is the trim value plus one, so a trim of 32767 gives exactly 1 Hz.

Software reaches the block over a plain word-addressed register bus with a write strobe and a combinational read path. The time and the trim value are not changed at once. A write is parked in a pending stage and committed only after a fixed number of slow ticks, which stands in for a transfer into a slow clock domain. During that window a busy flag shows in the control/status word, and software polls it until it clears. The calendar honours month lengths and leap years from 1900 to 2099.

Top module: `rtcal_top`

## Requirements
- R1: After reset the trim register reads 32767, the time word reads 0x0420_0000 (1 January, 00:00:00), the year reads 1900, and the control/status word at 0x20 reads 0x120.
- R2: The time word at 0x0C holds the month in [31:26], the day in [25:21], the hour in [20:16], the minute in [15:10] and the second in [9:4]. Bits [3:0] always read zero, whatever was written. The year reads at 0x10.
- R3: A write to 0x04 (time word) or 0x08 (year) sets status bit 0. The bit clears on the third `slow_tick` after the write cycle, and the written value then reads back. With no ticks, the write stays pending and nothing changes.
- R4: A time or year write that arrives while one is pending restarts the three-tick count. Every field written since the last commit is committed together.
- R5: A write to 0x00 sets status bit 4 and commits the new trim three ticks later. A commit of the trim, or of the time, restarts the prescaler. After that, the seconds advance once per trim+1 ticks.
- R6: Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. Hours wrap from 23 to 0 and carry into the day.
- R7: The day wraps to 1 after the last day of its month: 30 days for April, June, September and November, and 31 for the other months except February. February has 29 days when the year is divisible by 4 and is neither 1900 nor 2100, and 28 days otherwise. The month wraps from 12 to 1 and adds one to the year.
- R8: The three match words at 0x14, 0x18 and 0x1C read back what was written and affect neither the time nor the busy bits. Writes to 0x0C, 0x10 and 0x20 are ignored.
- R9: Without `slow_tick` the prescaler and the time hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable at the 32.768 kHz rate |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |

## Verification
The bench loads calendar values that sit one or a few seconds before a boundary. These cover the hour carry, the ends of 30- and 31-day months, and year end. They also cover February in 2024, 2023, 2000, 1900 and 2100. A design with a wrong leap rule or a wrong month length would land on the wrong day after the boundary. The bench also stops the tick enable while a write is pending, to show that a design counting system clocks instead of ticks would commit early. It sends a second write into the busy window, to catch a design that commits on the original schedule or drops the earlier field. Finally, it times the first second after a commit, to catch a prescaler that does not restart or that divides by trim rather than trim+1.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;
   localparam int SEC_LSB = 4;
   localparam int MIN_LSB = 10;
   localparam int HR_LSB  = 16;
   localparam int DAY_LSB = 21;
   localparam int MON_LSB = 26;

   localparam int OFS_TRIM    = 'h00;
   localparam int OFS_SET_LO  = 'h04;
   localparam int OFS_SET_HI  = 'h08;
   localparam int OFS_GET_LO  = 'h0C;
   localparam int OFS_GET_HI  = 'h10;
   localparam int OFS_MATCH0  = 'h14;
   localparam int OFS_STATUS  = 'h20;

   localparam int ST_TIME_BUSY = 0;
   localparam int ST_TRIM_BUSY = 4;
   localparam int ST_OSC_OK    = 5;
   localparam int ST_RUNNING   = 8;

   localparam logic [31:0] RESET_YEAR = 32'd1900;

   function automatic logic leap_year(input logic [31:0] yr);
      return (yr[1:0] == 2'b00) && (yr != 32'd1900) && (yr != 32'd2100);
   endfunction

   function automatic logic [4:0] month_days(input logic [5:0] mon, input logic [31:0] yr);
      case (mon)
         6'd2:                      return leap_year(yr) ? 5'd29 : 5'd28;
         6'd4, 6'd6, 6'd9, 6'd11:   return 5'd30;
         default:                   return 5'd31;
      endcase
   endfunction
endpackage

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] trim,
   output logic             sec_tick
);
   logic [CNT_W-1:0] cnt_q;

   assign sec_tick = slow_tick && !restart && (cnt_q >= trim);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (restart)    cnt_q <= '0;
      else if (slow_tick)  cnt_q <= (cnt_q >= trim) ? '0 : cnt_q + 1'b1;
   end

   assert_tick_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> slow_tick);
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!slow_tick && !restart) |=> $stable(cnt_q));
   assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));
endmodule

// File: rtl/rtcal_stager.sv
module rtcal_stager #(
   parameter int SYNC_TICKS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic slow_tick,
   output logic busy,
   output logic commit
);
   localparam int CW = $clog2(SYNC_TICKS + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;

   initial begin
      assert (SYNC_TICKS >= 1) else $error("SYNC_TICKS must be at least 1");
   end

   assign busy   = busy_q;
   assign commit = busy_q && slow_tick && !load && (cnt_q == CW'(SYNC_TICKS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (commit) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q && slow_tick) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assert_load_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);
   assert_clear_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(slow_tick));
   assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !slow_tick) |=> busy);
endmodule

// File: rtl/rtcal_calendar.sv
module rtcal_calendar
   import rtcal_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sec_tick,
   input  logic        set_lo,
   input  logic [27:0] lo_fields,
   input  logic        set_hi,
   input  logic [31:0] hi_val,
   output logic [31:0] time_q,
   output logic [31:0] year_q
);
   logic [5:0] sec_q, min_q, mon_q;
   logic [4:0] hr_q, day_q;
   logic [31:0] yr_q;

   logic adv, c_min, c_hr, c_day, c_mon, c_yr;

   assign adv   = sec_tick && !set_lo && !set_hi;
   assign c_min = sec_q >= 6'd59;
   assign c_hr  = c_min && (min_q >= 6'd59);
   assign c_day = c_hr  && (hr_q  >= 5'd23);
   assign c_mon = c_day && (day_q >= month_days(mon_q, yr_q));
   assign c_yr  = c_mon && (mon_q >= 6'd12);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q <= '0; min_q <= '0; hr_q <= '0;
         day_q <= 5'd1; mon_q <= 6'd1; yr_q <= RESET_YEAR;
      end else begin
         if (set_lo) begin
            sec_q <= lo_fields[SEC_LSB-4 +: 6];
            min_q <= lo_fields[MIN_LSB-4 +: 6];
            hr_q  <= lo_fields[HR_LSB-4  +: 5];
            day_q <= lo_fields[DAY_LSB-4 +: 5];
            mon_q <= lo_fields[MON_LSB-4 +: 6];
         end else if (adv) begin
            sec_q <= c_min ? 6'd0 : sec_q + 6'd1;
            if (c_min) min_q <= c_hr  ? 6'd0 : min_q + 6'd1;
            if (c_hr)  hr_q  <= c_day ? 5'd0 : hr_q + 5'd1;
            if (c_day) day_q <= c_mon ? 5'd1 : day_q + 5'd1;
            if (c_mon) mon_q <= c_yr  ? 6'd1 : mon_q + 6'd1;
         end
         if (set_hi)                yr_q <= hi_val;
         else if (adv && c_yr)      yr_q <= yr_q + 32'd1;
      end
   end

   assign time_q = {mon_q, day_q, hr_q, min_q, sec_q, 4'b0000};
   assign year_q = yr_q;

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !set_lo && !set_hi) |=> ($stable(time_q) && $stable(year_q)));
   assert_tick_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (time_q != $past(time_q)));
   assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      time_q[3:0] == 4'b0000);
endmodule

// File: rtl/rtcal_top.sv
module rtcal_top
   import rtcal_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int PRESC_W    = 16,
   parameter int DEF_TRIM   = 32767,
   parameter int SYNC_TICKS = 3,
   parameter int NUM_MATCH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);
   localparam logic [31:0] RESET_TIME = (32'd1 << MON_LSB) | (32'd1 << DAY_LSB);

   initial begin
      assert (ADDR_W >= 6 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (PRESC_W >= 1 && PRESC_W <= 32) else $error("PRESC_W out of range");
      assert (DEF_TRIM >= 0 && DEF_TRIM < (64'd1 << PRESC_W)) else $error("DEF_TRIM does not fit");
      assert (NUM_MATCH >= 1 && NUM_MATCH <= 3) else $error("NUM_MATCH must be 1 to 3");
   end

   logic wr_trim, wr_lo, wr_hi;
   logic time_busy, time_commit, trim_busy, trim_commit, sec_tick;
   logic [31:0] pend_lo, pend_hi, time_q, year_q;
   logic        has_lo, has_hi;
   logic [PRESC_W-1:0] pend_trim, trim_q;
   logic [NUM_MATCH-1:0][31:0] match_q;

   assign wr_trim = bus_wr && (bus_addr == ADDR_W'(OFS_TRIM));
   assign wr_lo   = bus_wr && (bus_addr == ADDR_W'(OFS_SET_LO));
   assign wr_hi   = bus_wr && (bus_addr == ADDR_W'(OFS_SET_HI));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_lo   <= RESET_TIME;
         pend_hi   <= RESET_YEAR;
         has_lo    <= 1'b0;
         has_hi    <= 1'b0;
         pend_trim <= PRESC_W'(DEF_TRIM);
         trim_q    <= PRESC_W'(DEF_TRIM);
         match_q   <= '0;
      end else begin
         if (time_commit) begin
            has_lo <= 1'b0;
            has_hi <= 1'b0;
         end
         if (wr_lo) begin
            pend_lo <= {bus_wdata[31:4], 4'b0000};
            has_lo  <= 1'b1;
         end
         if (wr_hi) begin
            pend_hi <= bus_wdata;
            has_hi  <= 1'b1;
         end
         if (wr_trim)     pend_trim <= bus_wdata[PRESC_W-1:0];
         if (trim_commit) trim_q    <= pend_trim;
         for (int i = 0; i < NUM_MATCH; i++)
            if (bus_wr && bus_addr == ADDR_W'(OFS_MATCH0 + 4 * i)) match_q[i] <= bus_wdata;
      end
   end

   rtcal_stager #(.SYNC_TICKS(SYNC_TICKS)) u_time_stage (
      .clk(clk), .rst_n(rst_n), .load(wr_lo || wr_hi), .slow_tick(slow_tick),
      .busy(time_busy), .commit(time_commit));

   rtcal_stager #(.SYNC_TICKS(SYNC_TICKS)) u_trim_stage (
      .clk(clk), .rst_n(rst_n), .load(wr_trim), .slow_tick(slow_tick),
      .busy(trim_busy), .commit(trim_commit));

   rtcal_prescaler #(.CNT_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .restart(time_commit || trim_commit), .trim(trim_q), .sec_tick(sec_tick));

   rtcal_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .set_lo(time_commit && has_lo), .lo_fields(pend_lo[31:4]),
      .set_hi(time_commit && has_hi), .hi_val(pend_hi),
      .time_q(time_q), .year_q(year_q));

   always_comb begin
      bus_rdata = '0;
      case (int'(bus_addr))
         OFS_TRIM:   bus_rdata = 32'(trim_q);
         OFS_SET_LO: bus_rdata = pend_lo;
         OFS_SET_HI: bus_rdata = pend_hi;
         OFS_GET_LO: bus_rdata = time_q;
         OFS_GET_HI: bus_rdata = year_q;
         OFS_STATUS: begin
            bus_rdata[ST_RUNNING]   = 1'b1;
            bus_rdata[ST_OSC_OK]    = 1'b1;
            bus_rdata[ST_TRIM_BUSY] = trim_busy;
            bus_rdata[ST_TIME_BUSY] = time_busy;
         end
         default: ;
      endcase
      for (int i = 0; i < NUM_MATCH; i++)
         if (bus_addr == ADDR_W'(OFS_MATCH0 + 4 * i)) bus_rdata = match_q[i];
   end

   assert_match_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_MATCH0) && !time_busy && !trim_busy)
         |=> (!time_busy && !trim_busy));
   assert_trim_only_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !trim_commit |=> $stable(trim_q));
   assert_commit_clears_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      time_commit |=> (!has_lo && !has_hi));
endmodule

// File: tb/sim_rtcal_top.sv
module sim_rtcal_top;
   localparam int CLK_PERIOD = 10;
   localparam int TRIM_T = 3;

   typedef struct packed {
      int smo, sd, sh, smi, ss, sy, n, emo, ed, eh, emi, es, ey;
   } vec_t;

   localparam vec_t VEC [13] = '{
      '{1, 1, 0, 0, 0, 2024, 1,  1, 1, 0, 0, 1, 2024},
      '{3, 15, 10, 20, 59, 2024, 1,  3, 15, 10, 21, 0, 2024},
      '{6, 30, 23, 59, 59, 2023, 1,  7, 1, 0, 0, 0, 2023},
      '{12, 31, 23, 59, 59, 1999, 1,  1, 1, 0, 0, 0, 2000},
      '{2, 28, 23, 59, 59, 2024, 1,  2, 29, 0, 0, 0, 2024},
      '{2, 28, 23, 59, 59, 2023, 1,  3, 1, 0, 0, 0, 2023},
      '{2, 28, 23, 59, 59, 1900, 1,  3, 1, 0, 0, 0, 1900},
      '{2, 28, 23, 59, 59, 2000, 1,  2, 29, 0, 0, 0, 2000},
      '{2, 29, 23, 59, 59, 2024, 1,  3, 1, 0, 0, 0, 2024},
      '{4, 30, 23, 59, 59, 2025, 1,  5, 1, 0, 0, 0, 2025},
      '{1, 31, 23, 59, 58, 2025, 3,  2, 1, 0, 0, 1, 2025},
      '{2, 28, 23, 59, 59, 2100, 1,  3, 1, 0, 0, 0, 2100},
      '{8, 20, 13, 59, 59, 2050, 2,  8, 20, 14, 0, 1, 2050}
   };

   logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b1, bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   rtcal_top u0 (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
                 .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] pk(int mo, int d, int h, int mi, int s);
      return (32'(mo) << 26) | (32'(d) << 21) | (32'(h) << 16) | (32'(mi) << 10) | (32'(s) << 4);
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(int addr, logic [31:0] data);
      bus_addr = 6'(addr); bus_wdata = data; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(int addr, output logic [31:0] data);
      bus_addr = 6'(addr); #1; data = bus_rdata;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      cyc(3); rst_n = 1'b1; cyc(1);
      rd('h00, v); chk("R1 trim", v, 32'd32767);
      rd('h0C, v); chk("R1 time", v, 32'h0420_0000);
      rd('h10, v); chk("R1 year", v, 32'd1900);
      rd('h20, v); chk("R1 status", v, 32'h120);

      wr('h00, TRIM_T);
      rd('h20, v); chk("R5 trim busy", v, 32'h130);
      cyc(2); rd('h20, v); chk("R5 still busy", v, 32'h130);
      cyc(1); rd('h20, v); chk("R5 trim done", v, 32'h120);
      rd('h00, v); chk("R5 trim value", v, TRIM_T);

      slow_tick = 1'b0;
      wr('h04, pk(5, 10, 8, 30, 0) | 32'hF);
      rd('h20, v); chk("R3 busy", v, 32'h121);
      cyc(5); rd('h20, v); chk("R3 no tick keeps busy", v, 32'h121);
      rd('h0C, v); chk("R9 time held", v, 32'h0420_0000);
      slow_tick = 1'b1;
      cyc(2); rd('h20, v); chk("R3 two ticks busy", v, 32'h121);
      cyc(1); rd('h20, v); chk("R3 cleared", v, 32'h120);
      rd('h0C, v); chk("R2 low nibble zero", v, pk(5, 10, 8, 30, 0));
      rd('h10, v); chk("R3 year untouched", v, 32'd1900);
      cyc(TRIM_T); rd('h0C, v); chk("R5 not yet", v, pk(5, 10, 8, 30, 0));
      cyc(1); rd('h0C, v); chk("R5 one second", v, pk(5, 10, 8, 30, 1));

      wr('h04, pk(9, 9, 9, 9, 9));
      cyc(2); wr('h08, 32'd2030);
      cyc(2); rd('h20, v); chk("R4 restarted busy", v, 32'h121);
      cyc(1); rd('h20, v); chk("R4 cleared", v, 32'h120);
      rd('h0C, v); chk("R4 time", v, pk(9, 9, 9, 9, 9));
      rd('h10, v); chk("R4 year", v, 32'd2030);

      slow_tick = 1'b0;
      wr('h14, 32'hA5A5_0001); wr('h18, 32'h1234_5678); wr('h1C, 32'hFFFF_FFFF);
      wr('h0C, 32'h0); wr('h10, 32'h0); wr('h20, 32'hFFFF_FFFF);
      rd('h14, v); chk("R8 match0", v, 32'hA5A5_0001);
      rd('h18, v); chk("R8 match1", v, 32'h1234_5678);
      rd('h1C, v); chk("R8 match2", v, 32'hFFFF_FFFF);
      rd('h20, v); chk("R8 status", v, 32'h120);
      rd('h0C, v); chk("R8 time", v, pk(9, 9, 9, 9, 9));
      rd('h10, v); chk("R8 year", v, 32'd2030);
      cyc(20); rd('h0C, v); chk("R9 idle time", v, pk(9, 9, 9, 9, 9));
      slow_tick = 1'b1;

      for (int i = 0; i < 13; i++) begin
         wr('h04, pk(VEC[i].smo, VEC[i].sd, VEC[i].sh, VEC[i].smi, VEC[i].ss));
         wr('h08, VEC[i].sy);
         cyc(3);
         rd('h0C, v); chk("R3 vector load", v, pk(VEC[i].smo, VEC[i].sd, VEC[i].sh, VEC[i].smi, VEC[i].ss));
         cyc(VEC[i].n * (TRIM_T + 1));
         rd('h0C, v); chk("R6/R7 vector time", v, pk(VEC[i].emo, VEC[i].ed, VEC[i].eh, VEC[i].emi, VEC[i].es));
         rd('h10, v); chk("R7 vector year", v, VEC[i].ey);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule